// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting timer channel with a byte-wide programming interface. Software first writes a control byte that chooses how the count is transferred (low byte only, high byte only, or low then high) and which of four counting behaviours applies. It then writes the count one byte at a time on the data strobe. An external prescaler supplies a one-cycle `tick` enable at the nominal 1.193182 MHz rate. The channel drives a level output and a one-cycle interrupt request. Port decoding between several channels and tick generation are handled outside the block.

Two state machines drive the block. The byte-access machine has states NONE, WAIT_LO and WAIT_HI. Its transitions are: *configure*, a control byte enters WAIT_LO, or WAIT_HI in high-only mode. *Low byte*: WAIT_LO goes to WAIT_HI in low-then-high mode, otherwise it stays put and completes the count. *High byte*: WAIT_HI completes the count and returns to WAIT_LO in low-then-high mode. *Reject*: any data byte in NONE changes nothing. The run machine has states IDLE, PENDING and ACTIVE. Its transitions are: *stop*, an accepted control byte goes to IDLE. *Arm*, a completed count goes to PENDING, except when the channel is ACTIVE in rate mode. *Load*, the first tick in PENDING copies the reload value and goes to ACTIVE. *Wrap*, a terminal count in ACTIVE reloads the counter.

The control byte is laid out as follows. Bits 7:6 select the channel and must equal the `CHAN_ID` parameter. Bits 5:4 give the transfer mode: 0 latch, 1 low only, 2 high only, 3 low then high. Bits 3:1 give the counting mode: 0 terminal-count interrupt, 1 one-shot, 2 rate generator, 3 square wave, 4 and 5 strobes. Bit 0 is ignored, and counting is always binary.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset the output is low, no interrupt is raised, the channel is IDLE and waits for no byte. Ticks have no effect until a count is armed.
- R2: A control byte is ignored, with no change to output, counting or modes, when its bits 7:6 differ from `CHAN_ID`, when its bits 5:4 are 0, or when its bits 3:1 exceed 3.
- R3: An accepted control byte stops counting (IDLE). It drives the output low for mode 0 and high for modes 1, 2 and 3, in the cycle after the write.
- R4: In low-only mode each data byte replaces reload bits 7:0 and completes the count. In high-only mode each byte replaces bits 15:8 and completes the count.
- R5: In low-then-high mode the first byte replaces bits 7:0 and has no other effect. The second byte replaces bits 15:8 and completes the count. The next byte is again a low byte.
- R6: A completed count arms the channel. The first tick copies the reload value with no decrement. In modes 0 to 2, terminal count falls on tick N+1 after the write, with N the reload value and 0 meaning 65536.
- R7: In mode 0 a completed count drives the output low. The output rises at the first terminal count and stays high over later wraps, with a one-cycle interrupt only at that rise.
- R8: In mode 2 the output is high, the counter wraps every N ticks, and each terminal count gives a one-cycle interrupt.
- R9: In mode 2 a count completed while ACTIVE does not restart the channel. The running period ends on schedule and the new value applies from that wrap on.
- R10: In mode 3 the counter steps by 2 and the output toggles every ceil(N/2) ticks, starting high. Each rising edge gives a one-cycle interrupt.
- R11: In mode 1 a completed count drives the output high. It stays high and no interrupt is raised.
- R12: A data byte written while no byte is awaited (state NONE) changes neither the reload value nor any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| data_wr | input | 1 | Count byte write strobe |
| wdata | input | BYTE_W | Write data for both strobes |
| tick | input | 1 | One-cycle count enable from the time base |
| out_pin | output | 1 | Timer output level |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that at most one of `ctrl_wr` and `data_wr` is high in any cycle. Several also assume that no write arrives in the same cycle as a load tick or a wrap, so that the priority of a control byte over a data byte or a tick never needs resolving. The stimulus issues every write in a cycle of its own with `tick` low, and runs ticks back to back between writes. The sweeps cover each counting mode with reload values 1 through 9, and separate scenarios cover the reload-zero case, ignored control bytes and rejected data bytes.

// File: rtl/itc_pkg.sv
package itc_pkg;

    typedef enum logic [1:0] {
        RUN_IDLE,
        RUN_PENDING,
        RUN_ACTIVE
    } run_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_WAIT_LO,
        ACC_WAIT_HI
    } acc_t;

    // Encoding is decoded from control byte bits 5:4.
    typedef enum logic [1:0] {
        XFER_LATCH,
        XFER_LO,
        XFER_HI,
        XFER_LOHI
    } xfer_t;

    // Encoding is decoded from control byte bits 3:1.
    typedef enum logic [2:0] {
        OP_TERM_IRQ,
        OP_ONE_SHOT,
        OP_RATE,
        OP_SQUARE,
        OP_SW_STROBE,
        OP_HW_STROBE,
        OP_RSV6,
        OP_RSV7
    } op_t;

    typedef struct packed {
        logic [1:0] sel;
        xfer_t      xfer;
        op_t        op;
        logic       bcd;
    } ctrl_word_t;

endpackage

// File: rtl/itc_ctrl_regs.sv
module itc_ctrl_regs
    import itc_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [7:0] cw_byte,
    output logic       cfg_load,
    output xfer_t      cfg_xfer,
    output op_t        cfg_op,
    output op_t        mode_q
);

    localparam logic [1:0] SEL = CHAN_ID[1:0];

    ctrl_word_t cw;
    logic       mode_ok;
    logic       bcd_unused;

    // Decode of the control byte
    always_comb begin
        cw         = ctrl_word_t'(cw_byte);
        bcd_unused = cw.bcd;
        mode_ok    = cw.op inside {OP_TERM_IRQ, OP_ONE_SHOT, OP_RATE, OP_SQUARE};
        cfg_load   = ctrl_wr && (cw.sel == SEL) && (cw.xfer != XFER_LATCH) && mode_ok;
        cfg_xfer   = cw.xfer;
        cfg_op     = cw.op;
    end

    // Operating mode register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OP_TERM_IRQ;
        end else if (cfg_load) begin
            mode_q <= cw.op;
        end
    end

endmodule

// File: rtl/itc_access_fsm.sv
module itc_access_fsm
    import itc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  xfer_t               cfg_xfer,
    input  logic                data_wr,
    input  logic [BYTE_W-1:0]   wdata,
    output acc_t                acc_q,
    output logic [2*BYTE_W-1:0] reload_q,
    output logic                count_done
);

    localparam int CNT_W = 2 * BYTE_W;

    acc_t  acc_d;
    xfer_t xfer_q;
    logic  lo_we;
    logic  hi_we;

    // Next state and byte enables
    always_comb begin
        acc_d      = acc_q;
        count_done = 1'b0;
        lo_we      = 1'b0;
        hi_we      = 1'b0;
        if (cfg_load) begin
            acc_d = (cfg_xfer == XFER_HI) ? ACC_WAIT_HI : ACC_WAIT_LO;
        end else if (data_wr) begin
            unique case (acc_q)
                ACC_NONE: begin
                    acc_d = ACC_NONE;
                end
                ACC_WAIT_LO: begin
                    lo_we = 1'b1;
                    if (xfer_q == XFER_LOHI) begin
                        acc_d = ACC_WAIT_HI;
                    end else begin
                        count_done = 1'b1;
                    end
                end
                ACC_WAIT_HI: begin
                    hi_we      = 1'b1;
                    count_done = 1'b1;
                    if (xfer_q == XFER_LOHI) begin
                        acc_d = ACC_WAIT_LO;
                    end
                end
                default: begin
                    acc_d = ACC_NONE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= ACC_NONE;
            xfer_q <= XFER_LATCH;
        end else begin
            acc_q <= acc_d;
            if (cfg_load) begin
                xfer_q <= cfg_xfer;
            end
        end
    end

    // Reload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else begin
            if (lo_we) begin
                reload_q[BYTE_W-1:0] <= wdata;
            end
            if (hi_we) begin
                reload_q[CNT_W-1:BYTE_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/itc_count_core.sv
module itc_count_core
    import itc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_load,
    input  logic             count_done,
    input  op_t              mode,
    input  logic [CNT_W-1:0] reload,
    output run_t             run_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             restart,
    output logic             tc
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    run_t             run_d;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] step;
    logic             terminal;

    // Terminal detection and next state
    always_comb begin
        restart  = count_done && !cfg_load
                   && !((mode == OP_RATE) && (run_q == RUN_ACTIVE));
        step     = (mode == OP_SQUARE) ? TWO : ONE;
        terminal = (mode == OP_SQUARE) ? ((cnt_q == ONE) || (cnt_q == TWO))
                                       : (cnt_q == ONE);
        tc       = tick && (run_q == RUN_ACTIVE) && terminal && !cfg_load && !restart;
        run_d    = run_q;
        cnt_d    = cnt_q;
        if (cfg_load) begin
            run_d = RUN_IDLE;
        end else if (restart) begin
            run_d = RUN_PENDING;
        end else if (tick) begin
            unique case (run_q)
                RUN_IDLE: begin
                    run_d = RUN_IDLE;
                end
                RUN_PENDING: begin
                    run_d = RUN_ACTIVE;
                    cnt_d = reload;
                end
                RUN_ACTIVE: begin
                    cnt_d = terminal ? reload : (cnt_q - step);
                end
                default: begin
                    run_d = RUN_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= RUN_IDLE;
            cnt_q <= '0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/itc_out_ctrl.sv
module itc_out_ctrl
    import itc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_load,
    input  op_t  cfg_op,
    input  logic restart,
    input  op_t  mode,
    input  logic tc,
    output logic out_q,
    output logic irq_q
);

    logic out_d;
    logic irq_d;

    // Output level and interrupt event
    always_comb begin
        out_d = out_q;
        irq_d = 1'b0;
        if (cfg_load) begin
            out_d = (cfg_op != OP_TERM_IRQ);
        end else if (restart) begin
            out_d = (mode != OP_TERM_IRQ);
        end else if (tc) begin
            unique case (mode)
                OP_TERM_IRQ, OP_ONE_SHOT, OP_RATE: out_d = 1'b1;
                OP_SQUARE:                         out_d = ~out_q;
                default:                           out_d = out_q;
            endcase
            irq_d = (mode == OP_RATE) || (out_d && !out_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            out_q <= out_d;
            irq_q <= irq_d;
        end
    end

endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
    import itc_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    output logic              out_pin,
    output logic              irq
);

    localparam int CNT_W = 2 * BYTE_W;

    logic             cfg_load;
    xfer_t            cfg_xfer;
    op_t              cfg_op;
    op_t              mode_q;
    acc_t             acc_q;
    logic [CNT_W-1:0] reload_q;
    logic             count_done;
    run_t             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             restart;
    logic             tc;

    itc_ctrl_regs #(
        .CHAN_ID (CHAN_ID)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .cw_byte  (wdata[7:0]),
        .cfg_load (cfg_load),
        .cfg_xfer (cfg_xfer),
        .cfg_op   (cfg_op),
        .mode_q   (mode_q)
    );

    itc_access_fsm #(
        .BYTE_W (BYTE_W)
    ) u_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_xfer   (cfg_xfer),
        .data_wr    (data_wr),
        .wdata      (wdata),
        .acc_q      (acc_q),
        .reload_q   (reload_q),
        .count_done (count_done)
    );

    itc_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cfg_load   (cfg_load),
        .count_done (count_done),
        .mode       (mode_q),
        .reload     (reload_q),
        .run_q      (run_q),
        .cnt_q      (cnt_q),
        .restart    (restart),
        .tc         (tc)
    );

    itc_out_ctrl u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_op   (cfg_op),
        .restart  (restart),
        .mode     (mode_q),
        .tc       (tc),
        .out_q    (out_pin),
        .irq_q    (irq)
    );

endmodule

// File: rtl/itc_checker.sv
module itc_checker
    import itc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             data_wr,
    input logic             tick,
    input logic             out_pin,
    input logic             irq,
    input run_t             run,
    input acc_t             acc,
    input op_t              mode,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run == RUN_IDLE) |=> !irq);

    assert_pending_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run == RUN_PENDING && tick && !ctrl_wr && !data_wr)
        |=> (run == RUN_ACTIVE && cnt == $past(reload)));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode != OP_RATE) |=> !irq);

    assert_term_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OP_TERM_IRQ && out_pin && !ctrl_wr && !data_wr) |=> out_pin);

    assert_rate_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OP_RATE && run == RUN_ACTIVE) |-> out_pin);

    assert_rate_keeps_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OP_RATE && run == RUN_ACTIVE && data_wr && !ctrl_wr)
        |=> (run == RUN_ACTIVE));

    assert_one_shot_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OP_ONE_SHOT && $past(mode) == OP_ONE_SHOT) |-> !irq);

    assert_reject_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_NONE && data_wr && !ctrl_wr)
        |=> ($stable(reload) && acc == ACC_NONE && run == RUN_IDLE));

endmodule

bind interval_timer_channel itc_checker #(.CNT_W(CNT_W)) u_itc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .data_wr (data_wr),
    .tick    (tick),
    .out_pin (out_pin),
    .irq     (irq),
    .run     (run_q),
    .acc     (acc_q),
    .mode    (mode_q),
    .cnt     (cnt_q),
    .reload  (reload_q)
);

// File: tb/tb_interval_timer_channel.sv
`timescale 1ns/1ps
module tb_interval_timer_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       tick = 1'b0;
    logic       out_pin;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int irq_seen;

    always #2.5 clk = ~clk;

    interval_timer_channel dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .data_wr (data_wr),
        .wdata   (wdata),
        .tick    (tick),
        .out_pin (out_pin),
        .irq     (irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step_tick();
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        if (irq) irq_seen++;
    endtask

    task automatic put_ctrl(logic [7:0] b);
        ctrl_wr = 1'b1;
        wdata   = b;
        @(posedge clk);
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic put_data(logic [7:0] b);
        data_wr = 1'b1;
        wdata   = b;
        @(posedge clk);
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    function automatic logic [7:0] cw(int xfer, int op);
        return {2'b00, 2'(xfer), 3'(op), 1'b0};
    endfunction

    function automatic int exp_out(int op, int n, int k);
        int h = (n + 1) / 2;
        case (op)
            0:       return (k >= n + 1) ? 1 : 0;
            3:       return (((k - 1) / h) % 2 == 0) ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_irq(int op, int n, int k);
        int h = (n + 1) / 2;
        case (op)
            0:       return (k == n + 1) ? 1 : 0;
            2:       return (k >= 2 && (k - 1) % n == 0) ? 1 : 0;
            3:       return (k > 1 && (k - 1) % h == 0 && ((k - 1) / h) % 2 == 0) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string tag(int op);
        case (op)
            0:       return "R7 mode0";
            1:       return "R11 mode1";
            2:       return "R8 mode2";
            default: return "R10 mode3";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all R): got 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, ticks do nothing
        chk("R1 out after reset", out_pin, 0);
        chk("R1 irq after reset", irq, 0);
        irq_seen = 0;
        for (int k = 0; k < 5; k++) step_tick();
        chk("R1 out with ticks while idle", out_pin, 0);
        chk("R1 no irq while idle", irq_seen, 0);

        // R12: data byte before any control byte is rejected; R4 high-only load
        put_data(8'h05);
        put_ctrl(cw(2, 0));
        chk("R3 mode0 control drives low", out_pin, 0);
        put_data(8'h01);
        irq_seen = 0;
        for (int k = 1; k <= 260; k++) begin
            step_tick();
            if (k == 256) chk("R12 reload untouched by rejected byte (tick 256)", out_pin, 0);
            if (k == 257) begin
                chk("R4 high-only count 256 terminal", out_pin, 1);
                chk("R12 irq at tick 257", irq, 1);
            end
        end
        chk("R7 single irq after high-only load", irq_seen, 1);

        // R2: ignored control bytes
        put_ctrl(cw(3, 0));
        put_data(8'd10);
        put_data(8'd0);
        for (int k = 1; k <= 3; k++) step_tick();
        put_ctrl(8'h74);
        chk("R2 other channel ignored", out_pin, 0);
        put_ctrl(8'h04);
        chk("R2 latch transfer ignored", out_pin, 0);
        put_ctrl(8'h18);
        chk("R2 strobe mode ignored", out_pin, 0);
        put_ctrl(8'h1E);
        chk("R2 mode 7 ignored", out_pin, 0);
        irq_seen = 0;
        for (int k = 4; k <= 25; k++) begin
            step_tick();
            if (k == 10) chk("R2 count undisturbed (tick 10)", out_pin, 0);
            if (k == 11) begin
                chk("R2 count undisturbed (tick 11)", out_pin, 1);
                chk("R7 irq at rise", irq, 1);
            end
        end
        chk("R7 output stays high", out_pin, 1);
        chk("R7 one irq over several wraps", irq_seen, 1);

        // R3: control byte stops counting and sets output
        put_ctrl(cw(3, 2));
        chk("R3 mode2 control drives high", out_pin, 1);
        put_data(8'd3);
        put_data(8'd0);
        irq_seen = 0;
        for (int k = 1; k <= 10; k++) step_tick();
        chk("R8 three wraps in ten ticks", irq_seen, 3);
        put_ctrl(cw(3, 2));
        irq_seen = 0;
        for (int k = 1; k <= 10; k++) step_tick();
        chk("R3 control byte stops counting", irq_seen, 0);
        put_ctrl(cw(3, 0));
        chk("R3 mode0 control low", out_pin, 0);
        put_ctrl(cw(3, 3));
        chk("R3 mode3 control high", out_pin, 1);
        put_ctrl(cw(3, 1));
        chk("R3 mode1 control high", out_pin, 1);

        // R5: low-then-high alternation
        put_ctrl(cw(3, 0));
        put_data(8'd3);
        irq_seen = 0;
        for (int k = 1; k <= 4; k++) step_tick();
        chk("R5 low byte alone does not arm", irq_seen, 0);
        chk("R5 low byte alone keeps output", out_pin, 0);
        put_data(8'd0);
        for (int k = 1; k <= 4; k++) begin
            step_tick();
            if (k == 3) chk("R5 count 3 before terminal", out_pin, 0);
            if (k == 4) chk("R5 count 3 terminal", out_pin, 1);
        end
        put_data(8'd2);
        chk("R5 next byte is low, no restart", out_pin, 1);
        put_data(8'd0);
        chk("R7 count write drives low", out_pin, 0);
        for (int k = 1; k <= 3; k++) begin
            step_tick();
            if (k == 2) chk("R5 count 2 before terminal", out_pin, 0);
            if (k == 3) chk("R5 count 2 terminal", out_pin, 1);
        end

        // R9: rate generator reloaded while running, low-only transfer (R4)
        put_ctrl(cw(1, 2));
        put_data(8'd5);
        for (int k = 1; k <= 20; k++) begin
            step_tick();
            chk("R9 rate irq schedule", irq,
                (k == 6 || k == 11 || k == 14 || k == 17 || k == 20) ? 1 : 0);
            if (k == 8) put_data(8'd3);
        end

        // Sweep of all four counting modes over small reload values
        for (int op = 0; op < 4; op++) begin
            for (int n = 1; n <= 9; n++) begin
                put_ctrl(cw(3, op));
                chk("R3 sweep control level", out_pin, (op != 0) ? 1 : 0);
                put_data(8'(n));
                put_data(8'd0);
                chk(tag(op), out_pin, (op != 0) ? 1 : 0);
                for (int k = 1; k <= 3 * n + 4; k++) begin
                    step_tick();
                    chk(tag(op), out_pin, exp_out(op, n, k));
                    chk(tag(op), irq, exp_irq(op, n, k));
                end
            end
        end

        // R6: reload zero means 65536
        put_ctrl(cw(3, 0));
        put_data(8'd0);
        put_data(8'd0);
        for (int k = 1; k <= 65537; k++) begin
            step_tick();
            if (k == 65536) chk("R6 zero reload before terminal", out_pin, 0);
            if (k == 65537) begin
                chk("R6 zero reload terminal", out_pin, 1);
                chk("R6 zero reload irq", irq, 1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule